// File: doc/BRIEF.md
# Expected-Packet Counter with Epoch Watchdog

This block sits at a destination network interface and tracks how many packets are still owed to the node. A lightweight side network sends an advance notice ahead of every packet; each notice raises a pending count by one. Each packet that the main network delivers lowers the count by one. The lowering is held back by a fixed number of cycles, so a packet that reaches the node slightly before its own notice cannot drive the count below zero.

A healthy network keeps draining to a zero count from time to time. A timer measures a programmable epoch. The epoch restarts every cycle in which the count is zero. If the count stays above zero for a whole epoch, some packet is stuck, and the block raises a recovery request. That request holds until a clear pulse. The block also compares the destination field of each arriving header with the node's own address and flags any mismatch as a misroute. The recovery sequence that follows is handled elsewhere.

Top module: `pkt_watch`

## Requirements
- R1: A notify pulse sampled at a clock edge raises `pending_o` by one after that edge, unless a delayed decrement lands on the same edge.
- R2: A deliver pulse sampled at edge E lowers `pending_o` by one at edge E+DEC_DELAY (default 4). The count holds its value through edge E+DEC_DELAY-1.
- R3: If a notify pulse and a delayed decrement land on the same edge, `pending_o` keeps its value.
- R4: `pending_o` saturates at 2^CNT_W-1 (255 by default) and does not wrap.
- R5: A delayed decrement that arrives while the count is zero leaves the count at zero and sets `underflow_o`. The flag stays set until `clear_i`.
- R6: With `epoch_len_i` = L > 0, `recover_o` rises after the L-th consecutive edge at which `pending_o` was non-zero.
- R7: Any edge at which `pending_o` is zero restarts the epoch. Stretches of non-zero count shorter than L never raise `recover_o`.
- R8: Once high, `recover_o` stays high until `clear_i` is sampled high. `clear_i` also clears `underflow_o`.
- R9: `epoch_len_i` = 0 turns the watchdog off: `recover_o` never rises, however long the count stays above zero.
- R10: A header (`hdr_valid_i` high) whose `hdr_dest_i` differs from parameter NODE_ID (default 9) drives `misroute_o` high for the single cycle after its edge. A matching header leaves `misroute_o` low.
- R11: After reset, `pending_o` is 0 and `recover_o`, `underflow_o` and `misroute_o` are all low.
- R12: The epoch timer handles lengths of at least 7000 cycles. With L = 7000, `recover_o` is low after 6999 non-zero edges and high after 7000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| notify_i | input | 1 | Advance-notice strobe from the side network |
| deliver_i | input | 1 | Packet-delivered strobe from the main network |
| hdr_valid_i | input | 1 | Header present on `hdr_dest_i` |
| hdr_dest_i | input | NODE_W | Destination field of the arriving header |
| epoch_len_i | input | EPOCH_W | Epoch length in cycles; 0 turns the watchdog off |
| clear_i | input | 1 | Clears the recovery request and the underflow flag |
| pending_o | output | CNT_W | Count of packets still expected |
| recover_o | output | 1 | Recovery request, held until cleared |
| underflow_o | output | 1 | Sticky flag for a decrement at zero |
| misroute_o | output | 1 | One-cycle flag for a wrongly addressed header |

## Verification
A notify pulse changes the count one edge after it is sampled. A delivery changes the count DEC_DELAY edges after it is sampled. Misroute, underflow and clear responses each appear one edge after their cause. The recovery request appears exactly L edges after the count first becomes non-zero. The bench drives inputs and reads outputs only on falling edges. It counts rising edges from each stimulus and checks the output both on the edge just before it is due and on the edge at which it is due, so an off-by-one in the delay line or in the epoch comparison shows up. Coincident notify and decrement are produced by issuing the notify exactly DEC_DELAY cycles after the delivery.

// File: rtl/pkt_watch_pkg.sv
package pkt_watch_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_UP   = 2'd1,
    OP_DOWN = 2'd2
  } cnt_op_e;

  function automatic cnt_op_e pick_op(input logic up, input logic down);
    if (up && !down) return OP_UP;
    if (down && !up) return OP_DOWN;
    return OP_HOLD;
  endfunction
endpackage

// File: rtl/pw_dec_delay.sv
module pw_dec_delay #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic pulse_o
);
  generate
    if (DEPTH == 0) begin : g_bypass
      assign pulse_o = pulse_i;
    end else begin : g_shift
      logic [DEPTH-1:0] pipe_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q <= '0;
        else if (DEPTH == 1) pipe_q <= pulse_i;
        else pipe_q <= {pipe_q[DEPTH-2:0], pulse_i};
      end
      // final stage is consumed on the edge DEPTH cycles after capture
      assign pulse_o = pipe_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/pw_counter.sv
module pw_counter
  import pkt_watch_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             down_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             underflow_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             uflow_q;
  cnt_op_e          op;

  assign op = pick_op(up_i, down_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      uflow_q <= 1'b0;
    end else begin
      unique case (op)
        OP_UP:   if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
        OP_DOWN: begin
          if (cnt_q == '0) uflow_q <= 1'b1;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: cnt_q <= cnt_q;
      endcase
      if (clear_i) uflow_q <= 1'b0;
    end
  end

  assign cnt_o       = cnt_q;
  assign underflow_o = uflow_q;
endmodule

// File: rtl/pw_epoch.sv
module pw_epoch #(
  parameter int unsigned EPOCH_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               busy_i,
  input  logic [EPOCH_W-1:0] len_i,
  input  logic               clear_i,
  output logic               recover_o
);
  logic [EPOCH_W-1:0] tmr_q;
  logic [EPOCH_W:0]   tmr_nx;
  logic               expire;
  logic               rec_q;

  assign tmr_nx = {1'b0, tmr_q} + 1'b1;
  assign expire = busy_i && (len_i != '0) && (tmr_nx == {1'b0, len_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      rec_q <= 1'b0;
    end else begin
      if (!busy_i || expire || len_i == '0) tmr_q <= '0;
      else tmr_q <= tmr_nx[EPOCH_W-1:0];
      if (clear_i) rec_q <= 1'b0;
      else if (expire) rec_q <= 1'b1;
    end
  end

  assign recover_o = rec_q;
endmodule

// File: rtl/pw_route_chk.sv
module pw_route_chk #(
  parameter int unsigned     NODE_W  = 6,
  parameter logic [NODE_W-1:0] NODE_ID = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_valid_i,
  input  logic [NODE_W-1:0] hdr_dest_i,
  output logic              misroute_o
);
  logic mis_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mis_q <= 1'b0;
    else mis_q <= hdr_valid_i && (hdr_dest_i != NODE_ID);
  end
  assign misroute_o = mis_q;
endmodule

// File: rtl/pkt_watch.sv
module pkt_watch #(
  parameter int unsigned       CNT_W     = 8,
  parameter int unsigned       EPOCH_W   = 16,
  parameter int unsigned       DEC_DELAY = 4,
  parameter int unsigned       NODE_W    = 6,
  parameter logic [NODE_W-1:0] NODE_ID   = 6'd9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               notify_i,
  input  logic               deliver_i,
  input  logic               hdr_valid_i,
  input  logic [NODE_W-1:0]  hdr_dest_i,
  input  logic [EPOCH_W-1:0] epoch_len_i,
  input  logic               clear_i,
  output logic [CNT_W-1:0]   pending_o,
  output logic               recover_o,
  output logic               underflow_o,
  output logic               misroute_o
);
  logic dec_dly;
  logic [CNT_W-1:0] cnt;

  pw_dec_delay #(.DEPTH(DEC_DELAY)) i_delay (
    .clk_i, .rst_ni, .pulse_i(deliver_i), .pulse_o(dec_dly)
  );

  pw_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i, .rst_ni, .up_i(notify_i), .down_i(dec_dly), .clear_i,
    .cnt_o(cnt), .underflow_o
  );

  pw_epoch #(.EPOCH_W(EPOCH_W)) i_epoch (
    .clk_i, .rst_ni, .busy_i(cnt != '0), .len_i(epoch_len_i), .clear_i,
    .recover_o
  );

  pw_route_chk #(.NODE_W(NODE_W), .NODE_ID(NODE_ID)) i_route (
    .clk_i, .rst_ni, .hdr_valid_i, .hdr_dest_i, .misroute_o
  );

  assign pending_o = cnt;
endmodule

// File: rtl/pkt_watch_chk.sv
module pkt_watch_chk #(
  parameter int unsigned       CNT_W   = 8,
  parameter int unsigned       EPOCH_W = 16,
  parameter int unsigned       NODE_W  = 6,
  parameter logic [NODE_W-1:0] NODE_ID = 6'd9
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               notify_i,
  input logic               dec_dly,
  input logic               hdr_valid_i,
  input logic [NODE_W-1:0]  hdr_dest_i,
  input logic [EPOCH_W-1:0] epoch_len_i,
  input logic               clear_i,
  input logic [CNT_W-1:0]   pending_o,
  input logic               recover_o,
  input logic               underflow_o,
  input logic               misroute_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  a_r1_increment: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_i && !dec_dly && pending_o != CntMax |=> pending_o == $past(pending_o) + 1'b1);

  a_r3_coincide_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    notify_i && dec_dly |=> $stable(pending_o));

  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o == CntMax && !dec_dly |=> pending_o == CntMax);

  a_r5_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_dly && !notify_i && pending_o == '0 && !clear_i |=> underflow_o && pending_o == '0);

  a_r7_zero_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(recover_o) |-> $past(pending_o) != '0);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recover_o && !clear_i |=> recover_o);

  a_r9_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epoch_len_i == '0 && !recover_o |=> !recover_o);

  a_r10_misroute: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && hdr_dest_i != NODE_ID |=> misroute_o);
endmodule

bind pkt_watch pkt_watch_chk #(
  .CNT_W(CNT_W), .EPOCH_W(EPOCH_W), .NODE_W(NODE_W), .NODE_ID(NODE_ID)
) i_pkt_watch_chk (
  .clk_i, .rst_ni, .notify_i, .dec_dly, .hdr_valid_i, .hdr_dest_i,
  .epoch_len_i, .clear_i, .pending_o, .recover_o, .underflow_o, .misroute_o
);

// File: tb/test_pkt_watch.sv
`timescale 1ns/1ps
module test_pkt_watch;
  localparam int D = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       notify_i = 1'b0, deliver_i = 1'b0, hdr_valid_i = 1'b0, clear_i = 1'b0;
  logic [5:0] hdr_dest_i = '0;
  logic [15:0] epoch_len_i = '0;
  logic [7:0] pending_o;
  logic       recover_o, underflow_o, misroute_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pkt_watch i_pkt_watch (
    .clk_i, .rst_ni, .notify_i, .deliver_i, .hdr_valid_i, .hdr_dest_i,
    .epoch_len_i, .clear_i, .pending_o, .recover_o, .underflow_o, .misroute_o
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_notify();
    notify_i = 1'b1; step(); notify_i = 1'b0;
  endtask

  task automatic pulse_deliver();
    deliver_i = 1'b1; step(); deliver_i = 1'b0;
  endtask

  task automatic pulse_clear();
    clear_i = 1'b1; step(); clear_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 pending", pending_o, 0);
    chk("R11 recover", recover_o, 0);
    chk("R11 underflow", underflow_o, 0);
    chk("R11 misroute", misroute_o, 0);
  endtask

  task automatic t_inc();
    pulse_notify();
    chk("R1 first", pending_o, 1);
    pulse_notify(); pulse_notify();
    chk("R1 third", pending_o, 3);
  endtask

  task automatic t_delay();
    pulse_deliver();          // captured, edge E
    step(D - 1);              // after edge E+D-1
    chk("R2 before", pending_o, 3);
    step();                   // after edge E+D
    chk("R2 due", pending_o, 2);
  endtask

  task automatic t_coincide();
    pulse_deliver();          // edge E
    step(D - 1);
    pulse_notify();           // captured at edge E+D
    chk("R3 same edge", pending_o, 2);
    step();
    chk("R3 after", pending_o, 2);
  endtask

  task automatic t_underflow();
    pulse_deliver(); pulse_deliver();
    step(D + 1);
    chk("R5 drained", pending_o, 0);
    chk("R5 no flag yet", underflow_o, 0);
    pulse_deliver();
    step(D + 1);
    chk("R5 stays zero", pending_o, 0);
    chk("R5 flag", underflow_o, 1);
    step(3);
    chk("R5 sticky", underflow_o, 1);
    pulse_clear();
    chk("R8 clear underflow", underflow_o, 0);
  endtask

  task automatic t_saturate();
    notify_i = 1'b1; step(300); notify_i = 1'b0;
    chk("R4 saturate", pending_o, 255);
    chk("R9 off", recover_o, 0);
    deliver_i = 1'b1; step(255); deliver_i = 1'b0;
    step(D + 1);
    chk("R4 drain", pending_o, 0);
    chk("R4 no underflow", underflow_o, 0);
    chk("R9 still off", recover_o, 0);
  endtask

  task automatic run_epoch(input int len, input string tag);
    epoch_len_i = 16'(len);
    pulse_notify();           // edge E0, count 1
    step(len - 1);
    chk({tag, " early"}, recover_o, 0);
    step();
    chk({tag, " due"}, recover_o, 1);
    step(5);
    chk("R8 held", recover_o, 1);
    epoch_len_i = '0;
    pulse_clear();
    chk("R8 cleared", recover_o, 0);
    pulse_deliver();
    step(D + 1);
    chk({tag, " drained"}, pending_o, 0);
  endtask

  task automatic t_pass();
    epoch_len_i = 16'd20;
    for (int i = 0; i < 3; i++) begin
      pulse_notify();
      step(11);
      pulse_deliver();
      step(D + 1);
    end
    chk("R7 no trigger", recover_o, 0);
    chk("R7 zero", pending_o, 0);
    epoch_len_i = '0;
  endtask

  task automatic t_route();
    hdr_valid_i = 1'b1; hdr_dest_i = 6'd9; step();
    chk("R10 match", misroute_o, 0);
    hdr_dest_i = 6'd10; step();
    chk("R10 mismatch", misroute_o, 1);
    hdr_valid_i = 1'b0; hdr_dest_i = 6'd3; step();
    chk("R10 pulse ends", misroute_o, 0);
  endtask

  initial begin
    step(2);
    rst_ni = 1'b1;
    step();
    t_reset();
    t_inc();
    t_delay();
    t_coincide();
    t_underflow();
    t_saturate();
    run_epoch(20, "R6");
    t_pass();
    run_epoch(7000, "R12");
    t_route();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule